// File: doc/BRIEF.md
# Encoder Index Qualifier and Action Strobe Unit

This block takes the raw, active-low index input of an incremental encoder channel and turns each qualified index event into a single one-cycle command for the position counter. A two-bit function code picks the command. It can load the counter from its preset, clear the counter to zero, or capture the counter into its output latch. The fourth code issues no command. The counter and the registers themselves sit outside this block. Only the strobes leave it, together with a registered index-active level that the flag logic uses.

The index can be qualified in two ways. In the synchronous way, the synchronized index is sampled only on the filter clock enable that also paces the A/B filter. It must read active on `FILT_DEPTH` consecutive filter ticks. It is accepted only while the filtered A and B are equal, meaning both high or both low. In the asynchronous way, the synchronized index is used directly, with no filter tick and no phase condition. When the channel is not in quadrature mode, the synchronous way is overridden and the asynchronous way is always used. A separate enable removes the index from play in every mode.

Top module: `idx_ctrl`

## Requirements
- R1: While and directly after synchronous reset, all three strobes and `idx_active_o` are low.
- R2: A high level on `idx_n` is the inactive state. With `idx_n` held high, no strobe is produced, whatever A, B and the filter tick do.
- R3: On an accepted index, `idx_func` selects the strobe: 0 gives `ld_cnt_o`, 1 gives `clr_cnt_o`, 2 gives `ld_out_o`.
- R4: When `idx_func` is 3, an accepted index produces no strobe, but `idx_active_o` still rises.
- R5: Each activation of the qualified index produces exactly one strobe, one clock long, in the cycle where `idx_active_o` first goes high. No further strobe appears until the index has gone inactive and become active again.
- R6: In synchronous mode (`idx_sync_sel`=1 and `quad_mode`=1), the index is accepted only while `a_filt` equals `b_filt`. A held index with A different from B gives no strobe until the two agree.
- R7: In synchronous mode, the index is sampled only in cycles where `filt_tick` is high. With `filt_tick` held low, an active index has no effect.
- R8: In synchronous mode, an index active for fewer than `FILT_DEPTH` (default 2) consecutive tick samples is rejected. One held for longer is accepted.
- R9: With `quad_mode`=0, the index is handled asynchronously even when `idx_sync_sel`=1. It needs neither `filt_tick` nor agreement of A and B.
- R10: In quadrature mode with `idx_sync_sel`=0, the index is accepted at any A/B phase and without `filt_tick`.
- R11: With `idx_en`=0, no strobe is produced and `idx_active_o` stays low. Raising `idx_en` while the index is still held active then produces one strobe.
- R12: `idx_active_o` is high while the qualified index is active and falls after the index is released.
- R13: At most one of the three strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idx_n | input | 1 | Raw index, active low, asynchronous to clk |
| a_filt | input | 1 | Filtered A channel |
| b_filt | input | 1 | Filtered B channel |
| filt_tick | input | 1 | Filter clock enable, one clk cycle per filter period |
| idx_en | input | 1 | Index enable |
| idx_sync_sel | input | 1 | 1 selects synchronous qualification (quadrature only) |
| quad_mode | input | 1 | 1 for quadrature counting, 0 for non-quadrature |
| idx_func | input | 2 | Action code: 0 load, 1 clear, 2 capture, 3 none |
| ld_cnt_o | output | 1 | One-cycle strobe: load counter from preset |
| clr_cnt_o | output | 1 | One-cycle strobe: reset counter to zero |
| ld_out_o | output | 1 | One-cycle strobe: copy counter to output latch |
| idx_active_o | output | 1 | Registered level of the qualified index |

## Verification
Suppose the stored index level or the edge-detect state goes wrong. The ports then show a missing strobe, a repeated strobe, or an `idx_active_o` level that disagrees with the pin. This appears within the synchronizer depth plus a clock or two in asynchronous operation, and within `FILT_DEPTH` filter ticks plus two clocks in synchronous operation. A stuck tick sample history shows up as a short pulse being accepted, or as a held index never being accepted. A wrong mode mux shows up as a strobe under a phase or tick condition that should block it, or as no strobe where one is due.

// File: rtl/idx_pkg.sv
package idx_pkg;
  typedef enum logic [1:0] {
    IDX_FN_LOAD    = 2'd0,
    IDX_FN_CLEAR   = 2'd1,
    IDX_FN_CAPTURE = 2'd2,
    IDX_FN_NONE    = 2'd3
  } idx_fn_e;

  typedef struct packed {
    logic load;
    logic clear;
    logic capture;
  } idx_stb_t;
endpackage

// File: rtl/idx_sync_chain.sv
// Brings the asynchronous active-low index into the clk domain, active high.
module idx_sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_n,
  output logic act
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain[0] <= ~raw_n;
      for (int i = 1; i <= LAST; i++) chain[i] <= chain[i-1];
    end
  end

  assign act = chain[LAST];
endmodule

// File: rtl/idx_tick_filter.sv
// Samples a level on filter ticks; the output changes only after DEPTH
// consecutive samples agree.
module idx_tick_filter #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic din,
  output logic lvl
);
  localparam int HW = DEPTH - 1;

  logic [HW-1:0] hist;
  logic [HW:0]   window;

  assign window = {hist, din};

  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '0;
      lvl  <= 1'b0;
    end else if (tick) begin
      hist <= window[HW-1:0];
      if (&window)       lvl <= 1'b1;
      else if (~|window) lvl <= 1'b0;
    end
  end
endmodule

// File: rtl/idx_action_unit.sv
// Rising-edge detection of the qualified index and decode into one strobe.
module idx_action_unit
  import idx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       act,
  input  logic [1:0] func,
  output idx_stb_t   stb,
  output logic       active
);
  logic    rise;
  idx_fn_e fn;

  assign rise = act & ~active;
  assign fn   = idx_fn_e'(func);

  always_ff @(posedge clk) begin
    if (rst) begin
      stb    <= '0;
      active <= 1'b0;
    end else begin
      active      <= act;
      stb.load    <= rise && (fn == IDX_FN_LOAD);
      stb.clear   <= rise && (fn == IDX_FN_CLEAR);
      stb.capture <= rise && (fn == IDX_FN_CAPTURE);
    end
  end
endmodule

// File: rtl/idx_ctrl.sv
module idx_ctrl
  import idx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_DEPTH  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       idx_n,
  input  logic       a_filt,
  input  logic       b_filt,
  input  logic       filt_tick,
  input  logic       idx_en,
  input  logic       idx_sync_sel,
  input  logic       quad_mode,
  input  logic [1:0] idx_func,
  output logic       ld_cnt_o,
  output logic       clr_cnt_o,
  output logic       ld_out_o,
  output logic       idx_active_o
);
  logic     idx_async;
  logic     idx_filt;
  logic     use_sync;
  logic     phase_ok;
  logic     qual;
  idx_stb_t stb;

  idx_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .raw_n (idx_n),
    .act   (idx_async)
  );

  idx_tick_filter #(.DEPTH(FILT_DEPTH)) u_filt (
    .clk  (clk),
    .rst  (rst),
    .tick (filt_tick),
    .din  (idx_async),
    .lvl  (idx_filt)
  );

  // Non-quadrature operation always falls back to the asynchronous path.
  assign use_sync = idx_sync_sel & quad_mode;
  assign phase_ok = ~(a_filt ^ b_filt);
  assign qual     = idx_en & (use_sync ? (idx_filt & phase_ok) : idx_async);

  idx_action_unit u_act (
    .clk    (clk),
    .rst    (rst),
    .act    (qual),
    .func   (idx_func),
    .stb    (stb),
    .active (idx_active_o)
  );

  assign ld_cnt_o  = stb.load;
  assign clr_cnt_o = stb.clear;
  assign ld_out_o  = stb.capture;
endmodule

// File: rtl/idx_ctrl_chk.sv
module idx_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       idx_en,
  input logic [1:0] idx_func,
  input logic       ld_cnt_o,
  input logic       clr_cnt_o,
  input logic       ld_out_o,
  input logic       idx_active_o
);
  logic any_stb;
  assign any_stb = ld_cnt_o | clr_cnt_o | ld_out_o;

  // R13
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ld_cnt_o, clr_cnt_o, ld_out_o}));

  // R5
  strobe_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    any_stb |-> (idx_active_o && !$past(idx_active_o)));

  // R5
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    any_stb |=> !any_stb);

  // R4
  none_code_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(idx_func) == 2'd3) |-> !any_stb);

  // R11
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(idx_en) |-> (!any_stb && !idx_active_o));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (!any_stb && !idx_active_o));
endmodule

bind idx_ctrl idx_ctrl_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .idx_en       (idx_en),
  .idx_func     (idx_func),
  .ld_cnt_o     (ld_cnt_o),
  .clr_cnt_o    (clr_cnt_o),
  .ld_out_o     (ld_out_o),
  .idx_active_o (idx_active_o)
);

// File: tb/sim_idx_ctrl.sv
`timescale 1ns/1ps
module sim_idx_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       idx_n = 1'b1;
  logic       a_filt = 1'b0;
  logic       b_filt = 1'b0;
  logic       filt_tick = 1'b0;
  logic       idx_en = 1'b1;
  logic       idx_sync_sel = 1'b0;
  logic       quad_mode = 1'b1;
  logic [1:0] idx_func = 2'd0;
  logic       ld_cnt_o, clr_cnt_o, ld_out_o, idx_active_o;

  int n_chk = 0;
  int n_bad = 0;
  int c_ld = 0, c_clr = 0, c_cap = 0, c_multi = 0;

  always #5 clk = ~clk;

  idx_ctrl u0 (
    .clk(clk), .rst(rst), .idx_n(idx_n), .a_filt(a_filt), .b_filt(b_filt),
    .filt_tick(filt_tick), .idx_en(idx_en), .idx_sync_sel(idx_sync_sel),
    .quad_mode(quad_mode), .idx_func(idx_func),
    .ld_cnt_o(ld_cnt_o), .clr_cnt_o(clr_cnt_o), .ld_out_o(ld_out_o),
    .idx_active_o(idx_active_o)
  );

  always @(negedge clk) begin
    if (ld_cnt_o)  c_ld++;
    if (clr_cnt_o) c_clr++;
    if (ld_out_o)  c_cap++;
    if (int'(ld_cnt_o) + int'(clr_cnt_o) + int'(ld_out_o) > 1) c_multi++;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clr_counts();
    c_ld = 0; c_clr = 0; c_cap = 0;
  endtask

  task automatic release_idx();
    idx_n = 1'b1;
    cyc(8);
    clr_counts();
  endtask

  task automatic t_reset();
    rst = 1'b1; idx_n = 1'b0;
    cyc(4);
    check("R1 strobes in reset", int'(ld_cnt_o | clr_cnt_o | ld_out_o), 0);
    check("R1 active in reset", int'(idx_active_o), 0);
    idx_n = 1'b1;
    rst = 1'b0;
    cyc(1);
    check("R1 active after reset", int'(idx_active_o), 0);
    clr_counts();
  endtask

  task automatic t_func();
    quad_mode = 1'b1; idx_sync_sel = 1'b0;
    for (int f = 0; f < 4; f++) begin
      idx_func = 2'(f);
      idx_n = 1'b0;
      cyc(8);
      if (f == 3) begin
        check("R4 no strobe code 3", c_ld + c_clr + c_cap, 0);
      end else begin
        check("R3 load strobe", c_ld, (f == 0) ? 1 : 0);
        check("R3 clear strobe", c_clr, (f == 1) ? 1 : 0);
        check("R3 capture strobe", c_cap, (f == 2) ? 1 : 0);
      end
      check("R12 active while held", int'(idx_active_o), 1);
      release_idx();
      check("R12 inactive after release", int'(idx_active_o), 0);
    end
    idx_func = 2'd0;
  endtask

  task automatic t_hold();
    idx_n = 1'b0;
    cyc(40);
    check("R5 one strobe per hold", c_ld, 1);
    idx_n = 1'b1; cyc(6);
    idx_n = 1'b0; cyc(8);
    check("R5 second activation", c_ld, 2);
    release_idx();
  endtask

  task automatic t_high();
    idx_n = 1'b1; filt_tick = 1'b1;
    for (int s = 0; s < 2; s++) begin
      quad_mode = 1'b1; idx_sync_sel = s[0];
      for (int k = 0; k < 8; k++) begin
        a_filt = k[0]; b_filt = k[1];
        cyc(3);
      end
    end
    check("R2 high is inactive", c_ld + c_clr + c_cap, 0);
    filt_tick = 1'b0; idx_sync_sel = 1'b0; a_filt = 0; b_filt = 0;
  endtask

  task automatic t_sync_phase();
    quad_mode = 1'b1; idx_sync_sel = 1'b1; filt_tick = 1'b1;
    a_filt = 1'b1; b_filt = 1'b0;
    idx_n = 1'b0;
    cyc(12);
    check("R6 blocked when A!=B", c_ld, 0);
    check("R6 active low when A!=B", int'(idx_active_o), 0);
    b_filt = 1'b1;
    cyc(4);
    check("R6 accepted when A==B", c_ld, 1);
    release_idx();
    a_filt = 0; b_filt = 0;
  endtask

  task automatic t_tick();
    quad_mode = 1'b1; idx_sync_sel = 1'b1; filt_tick = 1'b0;
    idx_n = 1'b0;
    cyc(12);
    check("R7 no tick no effect", c_ld, 0);
    filt_tick = 1'b1;
    cyc(6);
    check("R7 accepted on ticks", c_ld, 1);
    release_idx();
  endtask

  task automatic t_glitch();
    quad_mode = 1'b1; idx_sync_sel = 1'b1; filt_tick = 1'b1;
    idx_n = 1'b0; cyc(1); idx_n = 1'b1;
    cyc(10);
    check("R8 short pulse rejected", c_ld, 0);
    idx_n = 1'b0; cyc(3); idx_n = 1'b1;
    cyc(10);
    check("R8 long pulse accepted", c_ld, 1);
    clr_counts();
  endtask

  task automatic t_nonquad();
    quad_mode = 1'b0; idx_sync_sel = 1'b1; filt_tick = 1'b0;
    a_filt = 1'b1; b_filt = 1'b0;
    idx_n = 1'b0;
    cyc(8);
    check("R9 nonquad forces async", c_ld, 1);
    release_idx();
    quad_mode = 1'b1;
  endtask

  task automatic t_async_phase();
    quad_mode = 1'b1; idx_sync_sel = 1'b0; filt_tick = 1'b0;
    a_filt = 1'b0; b_filt = 1'b1;
    idx_n = 1'b0;
    cyc(8);
    check("R10 async ignores phase", c_ld, 1);
    release_idx();
    a_filt = 0; b_filt = 0;
  endtask

  task automatic t_enable();
    quad_mode = 1'b1; idx_sync_sel = 1'b0;
    idx_en = 1'b0;
    idx_n = 1'b0;
    cyc(10);
    check("R11 disabled no strobe", c_ld, 0);
    check("R11 disabled active low", int'(idx_active_o), 0);
    idx_en = 1'b1;
    cyc(4);
    check("R11 enable while held", c_ld, 1);
    release_idx();
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_func();
    t_hold();
    t_high();
    t_sync_phase();
    t_tick();
    t_glitch();
    t_nonquad();
    t_async_phase();
    t_enable();
    check("R13 one strobe at a time", c_multi, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule